// File: doc/BRIEF.md
# Frame Acquisition Control and Status

This block is the host-facing control and status unit of a video capture engine. It holds two write-only control registers and one read-only status port, and it sequences the grab of one interlaced frame. The host writes control register 0 at offset 0 and control register 1 at offset 1. A read at offset 0 does not return control register 0. It returns a status byte built from the capture state and from the live video timing inputs.

A grab starts when the host writes control register 0 with the acquire bit set. The sequencer then waits for the next rising edge of vertical blank. It holds the capture-write enable through both fields of the frame and stops on the second vertical-blank rising edge after the start. When external triggering is enabled, the request first waits for the trigger input and only then arms for vertical blank. An ADC overflow seen during the capture is kept until the next capture starts. The end of a capture sets an interrupt status bit, and that bit drives the interrupt output when interrupts are enabled.

Top module: `fgrab_ctl`

## Requirements
- R1: A host write to offset 0 stores data bits 5:0 into control register 0, and a write to offset 1 stores them into control register 1. Both appear on `ctl0_o` / `ctl1_o` from the clock edge that samples the write. Bits 7:6 of both outputs are always zero. Writes to offsets 2 and 3 change neither register.
- R2: With `host_addr_i` = 0, `host_rdata_o` carries the status byte: bit 0 interrupt status, bit 1 sticky ADC overflow, bit 2 `field_i`, bit 3 `vblank_i`, bit 4 `trig_i`, bit 5 capture in progress. The input-driven bits follow their inputs in the same cycle. Offsets 1 to 3 read as 0x00.
- R3: Status bits 7:6 are always zero, so the status byte never reads 0xFF.
- R4: A write to offset 0 with bit 3 set, made while the sequencer is idle and with control register 1 bit 1 clear, arms a capture. `cap_wr_en_o` rises at the first clock edge that samples `vblank_i` high after it was low. It stays low before that edge.
- R5: The capture ends at the second vertical-blank rising edge after the one that started it. `cap_wr_en_o` is low from that edge onward.
- R6: Status bit 5 equals `cap_wr_en_o` at all times.
- R7: When control register 1 bit 1 (trigger enable) is set, a request waits until `trig_i` is sampled high. Vertical-blank edges before that point start nothing. After the trigger, the next vertical-blank rising edge starts the capture.
- R8: `adc_ovf_i` sampled high during a capture sets status bit 1, and the bit stays set. Bit 1 clears at the edge that starts the next capture. `adc_ovf_i` outside a capture has no effect.
- R9: The edge that ends a capture sets status bit 0, and the edge that starts the next capture clears it. `irq_o` is status bit 0 ANDed with control register 1 bit 0.
- R10: An acquire write made while a request is armed or a capture is running is ignored. It leaves no pending request behind.
- R11: After reset, both control outputs, `cap_wr_en_o`, `irq_o` and all stored status bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_i | input | 1 | Host write strobe, one cycle per write |
| host_addr_i | input | ADDR_W | Host port offset for both reads and writes |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Read data: status at offset 0, zero elsewhere |
| vblank_i | input | 1 | Vertical blanking interval, high while blanking |
| field_i | input | 1 | Current interlace field |
| trig_i | input | 1 | External trigger contact closed |
| adc_ovf_i | input | 1 | Digitiser reports a pixel out of range |
| ctl0_o | output | DATA_W | Control register 0 contents |
| ctl1_o | output | DATA_W | Control register 1 contents |
| cap_wr_en_o | output | 1 | Frame-store write enable, high during a capture |
| irq_o | output | 1 | Interrupt request |

## Verification
Control register contents and every state change of the capture sequencer appear one clock edge after the write or vertical-blank cycle that causes them. Status bits 2 to 4 are combinational and follow their inputs in the same cycle. The bench changes inputs only on falling clock edges. It reads every registered result at the next falling edge, which is exactly one rising edge after the stimulus. It reads the combinational status bits a short delay after changing the inputs. Each check on the start and end of a capture is made in the first half-cycle after the vertical-blank rising edge, so an extra or a missing register stage shows up as a failure.

// File: rtl/fgrab_pkg.sv
package fgrab_pkg;

    // number of implemented bits in each control register and in status
    localparam int unsigned CTL_BITS = 6;

    // host port offsets (status shares offset with control register 0)
    localparam int unsigned OFS_CTL0   = 0;
    localparam int unsigned OFS_CTL1   = 1;
    localparam int unsigned OFS_STATUS = 0;

    // control register 0 fields
    localparam int unsigned C0_PAGE_LO = 0;
    localparam int unsigned C0_ROTATE  = 2;
    localparam int unsigned C0_ACQ     = 3;
    localparam int unsigned C0_STORED  = 4;
    localparam int unsigned C0_LOWRES  = 5;

    // control register 1 fields
    localparam int unsigned C1_IRQ_EN  = 0;
    localparam int unsigned C1_TRIG_EN = 1;
    localparam int unsigned C1_LUT_LD  = 2;
    localparam int unsigned C1_BLANK   = 3;
    localparam int unsigned C1_BANK    = 4;
    localparam int unsigned C1_RAM_EN  = 5;

    // status byte fields
    localparam int unsigned ST_IRQ    = 0;
    localparam int unsigned ST_OVF    = 1;
    localparam int unsigned ST_FIELD  = 2;
    localparam int unsigned ST_VBLANK = 3;
    localparam int unsigned ST_TRIG   = 4;
    localparam int unsigned ST_BUSY   = 5;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_TRIG = 2'd1,
        SQ_ARM  = 2'd2,
        SQ_CAP  = 2'd3
    } sq_state_e;

endpackage

// File: rtl/fgrab_regs.sv
module fgrab_regs
    import fgrab_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] ctl0_o,
    output logic [DATA_W-1:0] ctl1_o,
    output logic              acq_req_o
);

    typedef struct packed {
        logic [CTL_BITS-1:0] c0;
        logic [CTL_BITS-1:0] c1;
    } regs_s;

    regs_s regs_d, regs_q;
    logic  hit_c0, hit_c1;

    always_comb begin
        regs_d = regs_q;
        hit_c0 = wr_en_i && (addr_i == ADDR_W'(OFS_CTL0));
        hit_c1 = wr_en_i && (addr_i == ADDR_W'(OFS_CTL1));
        if (hit_c0) begin
            regs_d.c0 = wdata_i[CTL_BITS-1:0];
        end
        if (hit_c1) begin
            regs_d.c1 = wdata_i[CTL_BITS-1:0];
        end
        // the request is the write strobe itself, not the stored level
        acq_req_o = hit_c0 && wdata_i[C0_ACQ];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    generate
        if (DATA_W > CTL_BITS) begin : g_pad
            logic unused_hi;
            assign unused_hi = ^wdata_i[DATA_W-1:CTL_BITS];
            assign ctl0_o = {{(DATA_W-CTL_BITS){1'b0}}, regs_q.c0};
            assign ctl1_o = {{(DATA_W-CTL_BITS){1'b0}}, regs_q.c1};
        end else begin : g_exact
            assign ctl0_o = regs_q.c0;
            assign ctl1_o = regs_q.c1;
        end
    endgenerate

endmodule

// File: rtl/fgrab_seq.sv
module fgrab_seq
    import fgrab_pkg::*;
#(
    parameter int unsigned FIELDS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acq_req_i,
    input  logic trig_en_i,
    input  logic trig_i,
    input  logic vblank_i,
    input  logic adc_ovf_i,
    output logic busy_o,
    output logic ovf_o,
    output logic done_o
);

    localparam int unsigned CNT_W = (FIELDS > 1) ? $clog2(FIELDS) : 1;
    localparam logic [CNT_W-1:0] LAST_FIELD = CNT_W'(FIELDS - 1);

    typedef struct packed {
        sq_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic             vb;
        logic             ovf;
        logic             done;
    } seq_s;

    seq_s seq_d, seq_q;
    logic vb_rise;

    always_comb begin
        seq_d   = seq_q;
        seq_d.vb = vblank_i;
        vb_rise = vblank_i && !seq_q.vb;

        unique case (seq_q.st)
            SQ_IDLE: begin
                if (acq_req_i) begin
                    seq_d.st = trig_en_i ? SQ_TRIG : SQ_ARM;
                end
            end
            SQ_TRIG: begin
                if (trig_i) begin
                    seq_d.st = SQ_ARM;
                end
            end
            SQ_ARM: begin
                if (vb_rise) begin
                    seq_d.st   = SQ_CAP;
                    seq_d.cnt  = '0;
                    seq_d.ovf  = 1'b0;
                    seq_d.done = 1'b0;
                end
            end
            SQ_CAP: begin
                if (adc_ovf_i) begin
                    seq_d.ovf = 1'b1;
                end
                if (vb_rise) begin
                    if (seq_q.cnt == LAST_FIELD) begin
                        seq_d.st   = SQ_IDLE;
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            default: seq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SQ_IDLE, cnt: '0, vb: 1'b0, ovf: 1'b0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o = (seq_q.st == SQ_CAP);
    assign ovf_o  = seq_q.ovf;
    assign done_o = seq_q.done;

endmodule

// File: rtl/fgrab_stat.sv
module fgrab_stat
    import fgrab_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              irq_st_i,
    input  logic              ovf_i,
    input  logic              field_i,
    input  logic              vblank_i,
    input  logic              trig_i,
    input  logic              busy_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] stat_byte;

    always_comb begin
        stat_byte            = '0;
        stat_byte[ST_IRQ]    = irq_st_i;
        stat_byte[ST_OVF]    = ovf_i;
        stat_byte[ST_FIELD]  = field_i;
        stat_byte[ST_VBLANK] = vblank_i;
        stat_byte[ST_TRIG]   = trig_i;
        stat_byte[ST_BUSY]   = busy_i;
        rdata_o = (addr_i == ADDR_W'(OFS_STATUS)) ? stat_byte : '0;
    end

endmodule

// File: rtl/fgrab_ctl.sv
module fgrab_ctl
    import fgrab_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned FIELDS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic [DATA_W-1:0] host_rdata_o,
    input  logic              vblank_i,
    input  logic              field_i,
    input  logic              trig_i,
    input  logic              adc_ovf_i,
    output logic [DATA_W-1:0] ctl0_o,
    output logic [DATA_W-1:0] ctl1_o,
    output logic              cap_wr_en_o,
    output logic              irq_o
);

    logic acq_req;
    logic seq_busy;
    logic seq_ovf;
    logic seq_done;

    fgrab_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (host_wr_i),
        .addr_i    (host_addr_i),
        .wdata_i   (host_wdata_i),
        .ctl0_o    (ctl0_o),
        .ctl1_o    (ctl1_o),
        .acq_req_o (acq_req)
    );

    fgrab_seq #(
        .FIELDS (FIELDS)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .acq_req_i (acq_req),
        .trig_en_i (ctl1_o[C1_TRIG_EN]),
        .trig_i    (trig_i),
        .vblank_i  (vblank_i),
        .adc_ovf_i (adc_ovf_i),
        .busy_o    (seq_busy),
        .ovf_o     (seq_ovf),
        .done_o    (seq_done)
    );

    fgrab_stat #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) stat_i (
        .addr_i   (host_addr_i),
        .irq_st_i (seq_done),
        .ovf_i    (seq_ovf),
        .field_i  (field_i),
        .vblank_i (vblank_i),
        .trig_i   (trig_i),
        .busy_i   (seq_busy),
        .rdata_o  (host_rdata_o)
    );

    assign cap_wr_en_o = seq_busy;
    assign irq_o       = seq_done && ctl1_o[C1_IRQ_EN];

endmodule

// File: rtl/fgrab_ctl_chk.sv
module fgrab_ctl_chk #(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vblank_i,
    input logic [ADDR_W-1:0] host_addr_i,
    input logic [DATA_W-1:0] host_rdata_o,
    input logic [DATA_W-1:0] ctl0_o,
    input logic [DATA_W-1:0] ctl1_o,
    input logic              cap_wr_en_o,
    input logic              irq_o,
    input logic              seq_ovf
);

    logic vb_d1;
    logic unused_chk;

    assign unused_chk = ^{ctl0_o[5:0], ctl1_o[5:1], host_rdata_o[5:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vb_d1 <= 1'b0;
        end else begin
            vb_d1 <= vblank_i;
        end
    end

    p_ctl_hi_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl0_o[DATA_W-1:6] == '0) && (ctl1_o[DATA_W-1:6] == '0));

    p_status_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr_i == '0) |-> (host_rdata_o[DATA_W-1:6] == '0));

    p_start_on_vblank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_wr_en_o) |-> ($past(vblank_i) && !$past(vb_d1)));

    p_end_on_vblank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cap_wr_en_o) |-> ($past(vblank_i) && !$past(vb_d1)));

    p_ovf_clear_at_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_wr_en_o) |-> !seq_ovf);

    p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ctl1_o[0]);

    p_irq_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cap_wr_en_o) && ctl1_o[0]) |-> irq_o);

endmodule

bind fgrab_ctl fgrab_ctl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .vblank_i     (vblank_i),
    .host_addr_i  (host_addr_i),
    .host_rdata_o (host_rdata_o),
    .ctl0_o       (ctl0_o),
    .ctl1_o       (ctl1_o),
    .cap_wr_en_o  (cap_wr_en_o),
    .irq_o        (irq_o),
    .seq_ovf      (seq_ovf)
);

// File: tb/fgrab_ctl_tb.sv
`timescale 1ns/1ps
module fgrab_ctl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [1:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       vblank = 1'b0;
    logic       field = 1'b0;
    logic       trig = 1'b0;
    logic       adc_ovf = 1'b0;
    logic [7:0] ctl0, ctl1;
    logic       cap_wr_en, irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fgrab_ctl #(.ADDR_W(2), .DATA_W(8), .FIELDS(2)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr_i    (host_wr),
        .host_addr_i  (host_addr),
        .host_wdata_i (host_wdata),
        .host_rdata_o (host_rdata),
        .vblank_i     (vblank),
        .field_i      (field),
        .trig_i       (trig),
        .adc_ovf_i    (adc_ovf),
        .ctl0_o       (ctl0),
        .ctl1_o       (ctl1),
        .cap_wr_en_o  (cap_wr_en),
        .irq_o        (irq)
    );

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    function automatic int stat_exp(input bit irqs, input bit ovf, input bit fld,
                                    input bit vb, input bit trg, input bit busy);
        return int'(irqs) + 2 * int'(ovf) + 4 * int'(fld) + 8 * int'(vb)
             + 16 * int'(trg) + 32 * int'(busy);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        host_wr = 1'b1;
        host_addr = a;
        host_wdata = d;
        tick();
        host_wr = 1'b0;
        host_addr = 2'd0;
    endtask

    task automatic read_at(input logic [1:0] a, output int v);
        host_addr = a;
        #0.5;
        v = int'(host_rdata);
        host_addr = 2'd0;
        #0.1;
    endtask

    // raise vertical blank; caller checks after this returns (one rising edge later)
    task automatic vb_up();
        vblank = 1'b1;
        tick();
    endtask

    task automatic vb_down();
        repeat (2) tick();
        vblank = 1'b0;
        repeat (5) tick();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=0x0 expected=0x1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R11 reset state
        check("R11 ctl0", int'(ctl0), 0);
        check("R11 ctl1", int'(ctl1), 0);
        check("R11 cap_wr_en", int'(cap_wr_en), 0);
        check("R11 irq", int'(irq), 0);
        read_at(2'd0, v);
        check("R11 status", v, 0);

        // R1 sweep of control register 1
        for (int i = 0; i < 256; i++) begin
            host_write(2'd1, 8'(i));
            check("R1 ctl1", int'(ctl1), i & 8'h3F);
        end
        host_write(2'd1, 8'h00);
        // R1 / R2 sweep of control register 0 (acquire bit kept clear)
        for (int i = 0; i < 256; i++) begin
            host_write(2'd0, 8'(i) & 8'hF7);
            check("R1 ctl0", int'(ctl0), i & 8'h37);
            read_at(2'd0, v);
            check("R2 status not ctl0", v, 0);
        end
        // R1 writes to offsets 2 and 3 ignored
        host_write(2'd2, 8'hFF);
        host_write(2'd3, 8'hFF);
        check("R1 ctl0 after ofs2/3", int'(ctl0), 8'h37);
        check("R1 ctl1 after ofs2/3", int'(ctl1), 0);
        // R2 other offsets read zero
        for (int a = 1; a < 4; a++) begin
            read_at(2'(a), v);
            check("R2 other offset", v, 0);
        end
        // R2 / R3 live input sweep while idle
        for (int i = 0; i < 8; i++) begin
            field = i[0];
            vblank = i[1];
            trig = i[2];
            read_at(2'd0, v);
            check("R2 live status", v, stat_exp(0, 0, i[0], i[1], i[2], 0));
            check("R3 never all ones", int'(v == 8'hFF), 0);
            tick();
        end
        field = 1'b0; vblank = 1'b0; trig = 1'b0;
        repeat (3) tick();

        // R4 capture without trigger
        host_write(2'd0, 8'h08);
        check("R4 armed not capturing", int'(cap_wr_en), 0);
        repeat (3) tick();
        check("R4 waits for vblank", int'(cap_wr_en), 0);
        vb_up();
        check("R4 start", int'(cap_wr_en), 1);
        read_at(2'd0, v);
        check("R6 busy bit", v, stat_exp(0, 0, 0, 1, 0, 1));
        vb_down();
        adc_ovf = 1'b1; tick(); adc_ovf = 1'b0; tick();
        read_at(2'd0, v);
        check("R8 sticky ovf", v, stat_exp(0, 1, 0, 0, 0, 1));
        host_write(2'd0, 8'h08); // R10 request while busy
        field = 1'b1;
        vb_up();
        check("R5 still capturing field 2", int'(cap_wr_en), 1);
        read_at(2'd0, v);
        check("R6 status field 2", v, stat_exp(0, 1, 1, 1, 0, 1));
        vb_down();
        field = 1'b0;
        vb_up();
        check("R5 end", int'(cap_wr_en), 0);
        read_at(2'd0, v);
        check("R9 done status", v, stat_exp(1, 1, 0, 1, 0, 0));
        check("R9 irq masked", int'(irq), 0);
        vb_down();
        host_write(2'd1, 8'h01);
        check("R9 irq enabled", int'(irq), 1);
        vb_up();
        check("R10 no pending request", int'(cap_wr_en), 0);
        vb_down();

        // second capture: clears at start
        host_write(2'd0, 8'h08);
        vb_up();
        check("R4 second start", int'(cap_wr_en), 1);
        read_at(2'd0, v);
        check("R8 R9 cleared at start", v, stat_exp(0, 0, 0, 1, 0, 1));
        check("R9 irq cleared", int'(irq), 0);
        vb_down();
        vb_up();
        vb_down();
        vb_up();
        check("R5 second end", int'(cap_wr_en), 0);
        check("R9 irq at end", int'(irq), 1);
        vb_down();
        adc_ovf = 1'b1; tick(); adc_ovf = 1'b0; tick();
        read_at(2'd0, v);
        check("R8 ovf ignored idle", v, stat_exp(1, 0, 0, 0, 0, 0));

        // R7 trigger mode
        host_write(2'd1, 8'h02);
        check("R9 irq disabled", int'(irq), 0);
        host_write(2'd0, 8'h08);
        vb_up();
        check("R7 no start before trigger", int'(cap_wr_en), 0);
        vb_down();
        trig = 1'b1;
        read_at(2'd0, v);
        check("R2 trig bit", v, stat_exp(1, 0, 0, 0, 1, 0));
        tick();
        trig = 1'b0;
        tick();
        check("R7 trigger alone no start", int'(cap_wr_en), 0);
        vb_up();
        check("R7 start after trigger", int'(cap_wr_en), 1);
        vb_down();
        vb_up();
        vb_down();
        vb_up();
        check("R7 end", int'(cap_wr_en), 0);
        vb_down();

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule